// File: doc/BRIEF.md
# Single-Wire Bus Mode and Wake-Up Controller

This block is the digital control core of a single-wire CAN physical layer. It takes two mode-select pins and decodes them into four operating states: sleep, high-voltage wake-up transmit, fast transmit and normal transmit. It turns the transmit-data pin into driver-control outputs and turns a digital bus-dominant flag from the analog comparator into a receive-data output. The analog drivers, comparators, waveshaping circuits and oscillator sit outside the block. The block only sees their digital flags and a periodic reference tick from which every delay is counted.

The block also drives a regulator-enable line. A filtered high-voltage wake level on the bus, seen while asleep, raises this line. The line also stays high while the host selects any non-sleep mode. Once both mode pins are low, the line stays high for a long hold interval and then drops. After that it ignores a high-voltage level that is still present, until that level goes away and comes back. While in sleep, the receive output is released unless a wake condition exists or has only just ended.

Top module: `swbus_mode_ctrl`

## Requirements
- R1: The mode index is {mode_sel0, mode_sel1}: 00 sleep, 01 high-voltage wake-up transmit, 10 fast, 11 normal. wave_en is 1 in modes 11 and 01 and 0 otherwise. hv_sel is 1 only in mode 01.
- R2: After reset, reg_en is 0, drv_on and drv_en are 0, rxd_out is 1 (released), and the mode is sleep.
- R3: In any non-sleep mode without undervoltage, drv_on is 1 when txd is 0 and 0 when txd is 1. In sleep mode, drv_on is always 0.
- R4: In any non-sleep mode without undervoltage, rxd_out is 0 while bus_dom is 1 and 1 while bus_dom is 0.
- R5: After drv_on goes from 1 to 0, drv_en stays 1 for exactly DRV_HOLD_TICKS ticks and then clears.
- R6: While uv_flag is 1, drv_on and drv_en are 0 and rxd_out is 1, whatever the mode, txd or bus state.
- R7: load_sw_en is 1 in every mode and 0 while gnd_lost is 1.
- R8: hv_wake counts as a wake only after it has been high for WAKE_FILT_TICKS ticks in a row. If it drops, the count starts again from zero.
- R9: reg_en rises when a filtered wake appears while asleep. It is also held at 1 whenever a non-sleep mode is selected.
- R10: In sleep mode, rxd_out is 1 with no wake, follows bus_dom (inverted) while the filtered wake is present, and keeps following for exactly RX_REL_TICKS ticks after the wake ends before it releases.
- R11: While awake with mode 00, reg_en drops after exactly HOLD_TICKS ticks, even if hv_wake is still high. It rises again only after hv_wake goes low and a new filtered wake is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle reference tick that times every delay |
| mode_sel0 | input | 1 | Mode select, upper index bit |
| mode_sel1 | input | 1 | Mode select, lower index bit |
| txd | input | 1 | Transmit data, 0 requests a dominant bus |
| bus_dom | input | 1 | Comparator flag, 1 when the bus is dominant |
| hv_wake | input | 1 | Comparator flag, 1 when a high-voltage wake level is present |
| uv_flag | input | 1 | Supply undervoltage flag |
| gnd_lost | input | 1 | Module ground-loss flag |
| drv_on | output | 1 | Drive the bus dominant |
| drv_en | output | 1 | Bus driver enable, includes the recessive hold |
| wave_en | output | 1 | Slew-limited waveshaping enable |
| hv_sel | output | 1 | Select the high-voltage drive level |
| rxd_out | output | 1 | Receive data, 1 is released or recessive |
| reg_en | output | 1 | Regulator enable |
| load_sw_en | output | 1 | Load-resistor switch enable |

## Verification
The bench steps ticks one at a time across each timed edge: the wake filter, the receive-release window, the driver hold and the regulator hold. An off-by-one counter would show up as an output that changes one tick early or late. It drops the wake level partway through the filter count, to expose a filter that only pauses instead of restarting. That fault would wake the block early. It keeps the wake level high across the hold timeout, to expose a controller that wakes again at once and never lets the regulator go. It also raises undervoltage while the driver hold is running, to expose an enable that lingers through a brownout.

// File: rtl/swbus_pkg.sv
// Shared types for the single-wire bus mode controller.
// Assumes the mode index is formed as {mode_sel0, mode_sel1}.
package swbus_pkg;

    typedef enum logic [1:0] {
        MD_SLEEP = 2'b00,
        MD_HVWU  = 2'b01,
        MD_FAST  = 2'b10,
        MD_NORM  = 2'b11
    } swb_mode_e;

endpackage

// File: rtl/swbus_sync.sv
// Multi-stage synchronizer for a vector of independent asynchronous flags.
// Each bit is synchronised on its own; no coherency between bits is assumed.
module swbus_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the raw asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Shift one stage further from metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/swbus_wake_ctrl.sv
// Wake filter, regulator-enable controller and sleep receive window.
// Assumes tick is a single-cycle pulse and all inputs are already synchronous.
module swbus_wake_ctrl
    import swbus_pkg::*;
#(
    parameter int WAKE_FILT_TICKS = 4,
    parameter int HOLD_TICKS      = 250000,
    parameter int RX_REL_TICKS    = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  swb_mode_e mode,
    input  logic      hv_s,
    output logic      wake_ok,
    output logic      rx_follow,
    output logic      reg_en
);
    localparam int FW = $clog2(WAKE_FILT_TICKS + 1);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam int RW = $clog2(RX_REL_TICKS + 1);
    localparam logic [FW-1:0] FILT_MAX = FW'(WAKE_FILT_TICKS);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
    localparam logic [RW-1:0] REL_LOAD = RW'(RX_REL_TICKS);

    logic [FW-1:0] flt_cnt;
    logic [HW-1:0] hold_cnt;
    logic [RW-1:0] win_cnt;
    logic          armed;
    logic          awake;
    logic          sleep_req;

    assign wake_ok   = (flt_cnt == FILT_MAX);
    assign sleep_req = (mode == MD_SLEEP);
    assign rx_follow = wake_ok || (win_cnt != '0);
    assign reg_en    = awake;

    // Count consecutive ticks of high-voltage level, restart on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n)            flt_cnt <= '0;
        else if (!hv_s)        flt_cnt <= '0;
        else if (tick && !wake_ok) flt_cnt <= flt_cnt + 1'b1;
    end

    // Arm a new wake only after the filtered level has been absent.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b1;
        else        armed <= !wake_ok;
    end

    // Regulator state: wake on a fresh level or host request, time out in sleep mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awake    <= 1'b0;
            hold_cnt <= '0;
        end else if (!awake) begin
            hold_cnt <= '0;
            if (!sleep_req || (wake_ok && armed)) awake <= 1'b1;
        end else if (!sleep_req) begin
            hold_cnt <= '0;
        end else if (tick) begin
            if (hold_cnt == HOLD_LAST) begin
                awake    <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // Keep the sleep receive path open for a short time after wake ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                     win_cnt <= '0;
        else if (wake_ok)               win_cnt <= REL_LOAD;
        else if (tick && win_cnt != '0) win_cnt <= win_cnt - 1'b1;
    end
endmodule

// File: rtl/swbus_tx_gate.sv
// Transmit gating: inverts transmit data into a dominant request and holds the
// driver enable for a number of ticks after the bus returns recessive.
// Assumes inputs are synchronous; outputs are registered.
module swbus_tx_gate
    import swbus_pkg::*;
#(
    parameter int DRV_HOLD_TICKS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  swb_mode_e mode,
    input  logic      txd_s,
    input  logic      uv_s,
    output logic      drv_on,
    output logic      drv_en,
    output logic      wave_en,
    output logic      hv_sel
);
    localparam int DW = $clog2(DRV_HOLD_TICKS + 1);
    localparam logic [DW-1:0] HOLD_LOAD = DW'(DRV_HOLD_TICKS);

    logic [DW-1:0] hold_cnt;
    logic          active;
    logic          req;

    assign active = (mode != MD_SLEEP) && !uv_s;
    assign req    = active && !txd_s;

    // Reload the hold while dominant, count it down on ticks once recessive.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hold_cnt <= '0;
        else if (!active)                  hold_cnt <= '0;
        else if (req)                      hold_cnt <= HOLD_LOAD;
        else if (tick && hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
    end

    // Register the driver control lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_on  <= 1'b0;
            drv_en  <= 1'b0;
            wave_en <= 1'b0;
            hv_sel  <= 1'b0;
        end else begin
            drv_on  <= req;
            drv_en  <= active && (req || hold_cnt != '0);
            wave_en <= (mode == MD_NORM) || (mode == MD_HVWU);
            hv_sel  <= (mode == MD_HVWU);
        end
    end
endmodule

// File: rtl/swbus_mode_ctrl.sv
// Top of the single-wire bus mode and wake-up controller. Synchronises the
// pins and flags, decodes the mode, and gates transmit, receive, regulator
// and load-switch controls. Assumes tick is synchronous to clk.
module swbus_mode_ctrl
    import swbus_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int WAKE_FILT_TICKS = 4,
    parameter int HOLD_TICKS      = 250000,
    parameter int RX_REL_TICKS    = 16,
    parameter int DRV_HOLD_TICKS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mode_sel0,
    input  logic mode_sel1,
    input  logic txd,
    input  logic bus_dom,
    input  logic hv_wake,
    input  logic uv_flag,
    input  logic gnd_lost,
    output logic drv_on,
    output logic drv_en,
    output logic wave_en,
    output logic hv_sel,
    output logic rxd_out,
    output logic reg_en,
    output logic load_sw_en
);
    localparam int NFLAG = 7;
    localparam logic [NFLAG-1:0] SYNC_RST = 7'b0010000;

    logic [NFLAG-1:0] raw_in;
    logic [NFLAG-1:0] syn;
    logic             m0_s, m1_s, txd_s, bus_s, hv_s, uv_s, gnd_s;
    swb_mode_e        mode_s;
    logic             wake_ok;
    logic             rx_follow;

    assign raw_in = {mode_sel0, mode_sel1, txd, bus_dom, hv_wake, uv_flag, gnd_lost};
    assign {m0_s, m1_s, txd_s, bus_s, hv_s, uv_s, gnd_s} = syn;
    assign mode_s = swb_mode_e'({m0_s, m1_s});

    swbus_sync #(
        .W       (NFLAG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    swbus_wake_ctrl #(
        .WAKE_FILT_TICKS (WAKE_FILT_TICKS),
        .HOLD_TICKS      (HOLD_TICKS),
        .RX_REL_TICKS    (RX_REL_TICKS)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode_s),
        .hv_s      (hv_s),
        .wake_ok   (wake_ok),
        .rx_follow (rx_follow),
        .reg_en    (reg_en)
    );

    swbus_tx_gate #(
        .DRV_HOLD_TICKS (DRV_HOLD_TICKS)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode_s),
        .txd_s   (txd_s),
        .uv_s    (uv_s),
        .drv_on  (drv_on),
        .drv_en  (drv_en),
        .wave_en (wave_en),
        .hv_sel  (hv_sel)
    );

    // Receive gating: released in undervoltage or in sleep with no wake window.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rxd_out <= 1'b1;
        else if (uv_s)                 rxd_out <= 1'b1;
        else if (mode_s != MD_SLEEP)   rxd_out <= !bus_s;
        else if (rx_follow)            rxd_out <= !bus_s;
        else                           rxd_out <= 1'b1;
    end

    // Load switch stays closed unless module ground is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) load_sw_en <= 1'b1;
        else        load_sw_en <= !gnd_s;
    end
endmodule

// File: rtl/swbus_mode_ctrl_sva.sv
// Property checker for swbus_mode_ctrl, attached by bind. Observes the
// synchronised mode and flags and the registered outputs.
module swbus_mode_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_s,
    input logic       uv_s,
    input logic       gnd_s,
    input logic       drv_on,
    input logic       drv_en,
    input logic       hv_sel,
    input logic       rxd_out,
    input logic       reg_en,
    input logic       load_sw_en
);
    a_r6_uv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (!drv_en && !drv_on && rxd_out));

    a_r7_load_open: assert property (@(posedge clk) disable iff (!rst_n)
        gnd_s |=> !load_sw_en);

    a_r7_load_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !gnd_s |=> load_sw_en);

    a_r3_sleep_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == 2'b00) |=> !drv_on);

    a_r1_hv_only_wake_mode: assert property (@(posedge clk) disable iff (!rst_n)
        hv_sel |-> ($past(mode_s) == 2'b01));

    a_r5_drive_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        drv_on |-> drv_en);

    a_r9_host_keeps_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s != 2'b00) |=> reg_en);

    a_r11_drop_only_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_en) |-> ($past(mode_s) == 2'b00));
endmodule

bind swbus_mode_ctrl swbus_mode_ctrl_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_s     (mode_s),
    .uv_s       (uv_s),
    .gnd_s      (gnd_s),
    .drv_on     (drv_on),
    .drv_en     (drv_en),
    .hv_sel     (hv_sel),
    .rxd_out    (rxd_out),
    .reg_en     (reg_en),
    .load_sw_en (load_sw_en)
);

// File: tb/swbus_mode_ctrl_test.sv
// Self-checking bench: a vector table for the static gating, then directed
// tests for reset, hold timers, wake filter and regulator timeout.
module swbus_mode_ctrl_test;
    localparam int WF  = 4;
    localparam int HLD = 40;
    localparam int RXR = 16;
    localparam int DH  = 16;
    localparam int NV  = 10;

    // {m0,m1,txd,bus,uv,gnd, exp drv_on,wave_en,hv_sel,rxd_out,load_sw_en}
    localparam logic [10:0] VEC [NV] = '{
        11'b110100_11001,
        11'b111000_01011,
        11'b100100_10001,
        11'b101100_00001,
        11'b010100_11101,
        11'b011001_01110,
        11'b110110_01011,
        11'b000100_00011,
        11'b101001_00010,
        11'b001001_00010
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic mode_sel0 = 1'b0, mode_sel1 = 1'b0, txd = 1'b1, bus_dom = 1'b0;
    logic hv_wake = 1'b0, uv_flag = 1'b0, gnd_lost = 1'b0;
    logic drv_on, drv_en, wave_en, hv_sel, rxd_out, reg_en, load_sw_en;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    swbus_mode_ctrl #(
        .SYNC_STAGES     (2),
        .WAKE_FILT_TICKS (WF),
        .HOLD_TICKS      (HLD),
        .RX_REL_TICKS    (RXR),
        .DRV_HOLD_TICKS  (DH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mode_sel0(mode_sel0), .mode_sel1(mode_sel1), .txd(txd),
        .bus_dom(bus_dom), .hv_wake(hv_wake), .uv_flag(uv_flag),
        .gnd_lost(gnd_lost), .drv_on(drv_on), .drv_en(drv_en),
        .wave_en(wave_en), .hv_sel(hv_sel), .rxd_out(rxd_out),
        .reg_en(reg_en), .load_sw_en(load_sw_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
        settle();
    endtask

    task automatic do_reset();
        mode_sel0 = 1'b0; mode_sel1 = 1'b0; txd = 1'b1; bus_dom = 1'b0;
        hv_wake = 1'b0; uv_flag = 1'b0; gnd_lost = 1'b0; tick = 1'b0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: reset state
        chk("R2 reg_en", reg_en, 1'b0);
        chk("R2 drv_on", drv_on, 1'b0);
        chk("R2 drv_en", drv_en, 1'b0);
        chk("R2 rxd_out", rxd_out, 1'b1);
        chk("R2 wave_en", wave_en, 1'b0);

        // R1 R3 R4 R6 R7: static gating table
        for (int v = 0; v < NV; v++) begin
            {mode_sel0, mode_sel1, txd, bus_dom, uv_flag, gnd_lost} = VEC[v][10:5];
            settle();
            chk("R3 drv_on", drv_on, VEC[v][4]);
            chk("R1 wave_en", wave_en, VEC[v][3]);
            chk("R1 hv_sel", hv_sel, VEC[v][2]);
            chk("R4 rxd_out", rxd_out, VEC[v][1]);
            chk("R7 load_sw_en", load_sw_en, VEC[v][0]);
        end

        // R5: driver enable hold after recessive
        do_reset();
        mode_sel0 = 1'b1; mode_sel1 = 1'b1; txd = 1'b0;
        settle();
        chk("R5 drv_en dominant", drv_en, 1'b1);
        txd = 1'b1;
        settle();
        chk("R3 drv_on recessive", drv_on, 1'b0);
        chk("R5 drv_en held", drv_en, 1'b1);
        do_ticks(DH - 1);
        chk("R5 drv_en last hold tick", drv_en, 1'b1);
        do_ticks(1);
        chk("R5 drv_en released", drv_en, 1'b0);
        // R6: undervoltage cuts a running hold
        txd = 1'b0; settle(); txd = 1'b1; settle();
        uv_flag = 1'b1;
        settle();
        chk("R6 drv_en in uv", drv_en, 1'b0);
        chk("R6 rxd_out in uv", rxd_out, 1'b1);
        uv_flag = 1'b0;

        // R8 R9 R10: wake filter and sleep receive
        do_reset();
        bus_dom = 1'b1; hv_wake = 1'b1;
        settle();
        do_ticks(WF - 1);
        chk("R8 no wake before filter", reg_en, 1'b0);
        chk("R10 rxd released asleep", rxd_out, 1'b1);
        hv_wake = 1'b0; settle();
        hv_wake = 1'b1; settle();
        do_ticks(WF - 1);
        chk("R8 filter restarted", reg_en, 1'b0);
        do_ticks(1);
        chk("R9 wake raises reg_en", reg_en, 1'b1);
        chk("R10 rxd follows in wake", rxd_out, 1'b0);
        hv_wake = 1'b0;
        settle();
        do_ticks(RXR - 1);
        chk("R10 rxd still follows", rxd_out, 1'b0);
        do_ticks(1);
        chk("R10 rxd released after window", rxd_out, 1'b1);

        // R11: regulator hold timeout with high voltage still present
        hv_wake = 1'b1; mode_sel0 = 1'b1; mode_sel1 = 1'b1;
        settle();
        do_ticks(WF + 1);
        mode_sel0 = 1'b0; mode_sel1 = 1'b0;
        settle();
        do_ticks(HLD - 1);
        chk("R11 reg_en before timeout", reg_en, 1'b1);
        do_ticks(1);
        chk("R11 reg_en at timeout", reg_en, 1'b0);
        do_ticks(8);
        chk("R11 no re-wake on stale level", reg_en, 1'b0);
        hv_wake = 1'b0; settle();
        hv_wake = 1'b1; settle();
        do_ticks(WF);
        chk("R11 fresh wake", reg_en, 1'b1);

        // R9: host selects a non-sleep mode
        do_reset();
        mode_sel0 = 1'b1; mode_sel1 = 1'b0;
        settle();
        chk("R9 host mode reg_en", reg_en, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule